// File: doc/BRIEF.md
# Rate-1/2 Convolutional Encoder with Stride Interleaver

This block protects a short fixed-size data block for a narrowband data link. It takes in a block of seven bytes one byte at a time: four payload bytes, two check bytes and one zero pad byte. Software or an upstream framer supplies all seven. The block runs every bit through a rate-1/2 convolutional code, which yields seven parity bytes. Each parity byte sits behind the data byte that produced it. The fourteen resulting bytes (112 bits) are then spread by a column-wrapping interleaver, so that a burst of line errors lands on bits that lie far apart in the code stream.

Bytes enter through a valid/ready stream and leave through a second valid/ready stream, which marks the fourteenth byte with a last flag. The block holds one block at a time. While it is draining the encoded bytes it refuses new input, and it opens its input again only once the final output byte has been taken. The check-byte computation, the sync header and the line coding belong to neighbouring blocks.

Top module: `fec_conv_ilv`

## Requirements
- R1: After reset the block signals `in_ready`=1, `out_valid`=0 and `out_last`=0.
- R2: `in_ready` and `out_valid` are never high in the same cycle (single buffering).
- R3: Once the seventh input byte of a block has been accepted, `out_valid` is high on the next cycle. `in_ready` then stays low until the fourteenth output byte has been accepted.
- R4: Each block yields exactly fourteen output bytes. `out_last` is high on the fourteenth byte only, and after that byte's handshake the block is ready for input again with `out_valid`=0.
- R5: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_last` hold their values into the next cycle.
- R6: Each input byte is taken bit 0 first into a 7-stage shift register, with stage 0 the newest bit. The parity bit is the XOR of stages 0, 2, 5 and 6 after the shift. The register is all zero at the start of every block. Parity bit j of input byte i becomes bit j of code byte i+7, and code byte i (for i<7) is input byte i unchanged.
- R7: Let code bit s be bit j of code byte b, so that s = 8b+j. Code bit s is placed at interleave position (s mod 7)·16 + floor(s/7). Output byte o carries positions 8o..8o+7, with position 8o in bit 7 and position 8o+7 in bit 0.
- R8: Input presented while the block is draining is not taken. It does not alter the current output block or the next one.
- R9: Gaps in `in_valid` and stalls on `out_ready` do not change the encoded bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Encoded byte available |
| out_ready | input | 1 | Consumer takes the encoded byte |
| out_data | output | 8 | Encoded, interleaved byte |
| out_last | output | 1 | Marks the fourteenth byte of a block |

## Verification
Every one of the 56 single-bit input blocks is encoded. Each of these shows on its own the parity taps and the interleave position reached by that one data bit. All-zero and all-ones blocks expose a stuck output bit and any tap that has been added or dropped. Random blocks are run back to back, some with input gaps, output stalls and junk offered during the drain. These show whether the shift register is cleared between blocks, whether the handshake is independent of the data, and whether input offered during the drain leaks into the block.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } fec_state_e;
endpackage

// File: rtl/fec_rst_sync.sv
module fec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/fec_conv_byte.sv
// One byte of the convolutional code, unrolled over its bits, LSB first.
module fec_conv_byte #(
  parameter int          SR_LEN = 7,
  parameter logic [SR_LEN-1:0] TAPS = 7'b1100101,
  parameter int          BYTE_W = 8
) (
  input  logic [SR_LEN-1:0] sr_cur,
  input  logic [BYTE_W-1:0] din,
  output logic [SR_LEN-1:0] sr_nxt,
  output logic [BYTE_W-1:0] par
);
  always_comb begin
    logic [SR_LEN-1:0] sr;
    sr  = sr_cur;
    par = '0;
    for (int j = 0; j < BYTE_W; j++) begin
      sr     = {sr[SR_LEN-2:0], din[j]};
      par[j] = ^(sr & TAPS);
    end
    sr_nxt = sr;
  end
endmodule

// File: rtl/fec_ilv_map.sv
// Column-wrapping interleaver as pure wiring: output position t reads code bit s.
module fec_ilv_map #(
  parameter int TOT_BITS = 112,
  parameter int STRIDE   = 16
) (
  input  logic [TOT_BITS-1:0] code_bits,
  output logic [TOT_BITS-1:0] ilv_bits
);
  localparam int ROWS = TOT_BITS / STRIDE;

  for (genvar t = 0; t < TOT_BITS; t++) begin : g_pos
    localparam int ROW = t / STRIDE;
    localparam int COL = t % STRIDE;
    assign ilv_bits[t] = code_bits[COL*ROWS + ROW];
  end
endmodule

// File: rtl/fec_conv_ilv.sv
module fec_conv_ilv
  import fec_pkg::*;
#(
  parameter int          BLK_BYTES = 7,
  parameter int          STRIDE    = 16,
  parameter int          SR_LEN    = 7,
  parameter logic [SR_LEN-1:0] TAPS = 7'b1100101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  localparam int OUT_BYTES = 2 * BLK_BYTES;
  localparam int TOT_BITS  = OUT_BYTES * BYTE_W;
  localparam int CNT_W     = $clog2(OUT_BYTES);

  logic rst_s_n;
  fec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  fec_state_e          st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SR_LEN-1:0]   sr_q, sr_d, sr_nx;
  logic [TOT_BITS-1:0] raw_q, raw_d, ilv;
  logic [BYTE_W-1:0]   par, sel;
  logic                in_fire, out_fire, ctl_en;

  fec_conv_byte #(.SR_LEN(SR_LEN), .TAPS(TAPS), .BYTE_W(BYTE_W)) u_conv (
    .sr_cur(sr_q), .din(in_data), .sr_nxt(sr_nx), .par(par)
  );

  fec_ilv_map #(.TOT_BITS(TOT_BITS), .STRIDE(STRIDE)) u_map (
    .code_bits(raw_q), .ilv_bits(ilv)
  );

  assign in_ready  = (st_q == ST_FILL);
  assign out_valid = (st_q == ST_DRAIN);
  assign in_fire   = in_ready && in_valid;
  assign out_fire  = out_valid && out_ready;
  assign ctl_en    = in_fire || out_fire;

  // next-state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sr_d  = sr_q;
    raw_d = raw_q;
    if (in_fire) begin
      sr_d = sr_nx;
      for (int b = 0; b < BLK_BYTES; b++) begin
        if (cnt_q == CNT_W'(b)) begin
          raw_d[b*BYTE_W +: BYTE_W]               = in_data;
          raw_d[(b+BLK_BYTES)*BYTE_W +: BYTE_W]   = par;
        end
      end
      if (cnt_q == CNT_W'(BLK_BYTES-1)) begin
        st_d  = ST_DRAIN;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (out_fire) begin
      if (cnt_q == CNT_W'(OUT_BYTES-1)) begin
        st_d  = ST_FILL;
        cnt_d = '0;
        sr_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q  <= ST_FILL;
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (ctl_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
    end
  end

  // code bit buffer, datapath without reset
  always_ff @(posedge clk) begin
    if (in_fire) raw_q <= raw_d;
  end

  // output byte select, first buffered bit into the MSB
  always_comb begin
    logic [BYTE_W-1:0] grp;
    grp = '0;
    for (int o = 0; o < OUT_BYTES; o++) begin
      if (cnt_q == CNT_W'(o)) grp = ilv[o*BYTE_W +: BYTE_W];
    end
    for (int p = 0; p < BYTE_W; p++) sel[BYTE_W-1-p] = grp[p];
  end

  assign out_data = sel;
  assign out_last = out_valid && (cnt_q == CNT_W'(OUT_BYTES-1));

  // R2: single buffering
  a_r2_single_buf: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(in_ready && out_valid));

  // R3: seventh accepted byte opens the drain
  a_r3_fill_done: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_fire && cnt_q == CNT_W'(BLK_BYTES-1)) |=> (out_valid && !in_ready));

  // R3: input stays closed while bytes remain
  a_r3_stay_closed: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !(out_ready && out_last)) |=> !in_ready);

  // R4: the last byte hands back to input
  a_r4_last_end: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_fire && out_last) |=> (in_ready && !out_valid));

  // R4: last only with valid
  a_r4_last_valid: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_last |-> out_valid);

  // R5: hold under backpressure
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: tb/fec_conv_ilv_tb_top.sv
`timescale 1ns/1ps
module fec_conv_ilv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, out_valid, out_ready, out_last;
  logic [7:0] in_data, out_data;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fec_conv_ilv dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reference model, written from the requirement text
  function automatic logic [111:0] ref_enc(input logic [55:0] blk);
    logic [111:0] code, lb, res;
    logic [6:0]   sr;
    int k, m;
    sr = '0;
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 8; j++) begin
        sr = {sr[5:0], blk[8*i+j]};
        code[8*i+j]     = blk[8*i+j];
        code[8*(i+7)+j] = sr[0] ^ sr[2] ^ sr[5] ^ sr[6];
      end
    end
    k = 0; m = 0;
    for (int s = 0; s < 112; s++) begin
      lb[k] = code[s];
      k += 16;
      if (k >= 112) begin m++; k = m; end
    end
    for (int o = 0; o < 14; o++)
      for (int p = 0; p < 8; p++)
        res[8*o + 7 - p] = lb[8*o + p];
    return res;
  endfunction

  task automatic run_block(input logic [55:0] blk, input bit gaps,
                           input bit bp, input bit junk, input string tag);
    logic [111:0] exp;
    exp = ref_enc(blk);
    for (int i = 0; i < 7; i++) begin
      if (gaps) repeat ($urandom % 3) @(negedge clk);
      in_valid = 1'b1;
      in_data  = blk[8*i +: 8];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
    end
    check("R3 out_valid after seventh byte", out_valid, 1);
    check("R3 in_ready low in drain", in_ready, 0);
    if (junk) begin in_valid = 1'b1; in_data = 8'($urandom); end
    for (int o = 0; o < 14; o++) begin
      if (bp) begin
        out_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
      end
      out_ready = 1'b1;
      while (!out_valid) @(negedge clk);
      check($sformatf("R6 R7 %s byte %0d", tag, o), out_data, exp[8*o +: 8]);
      check($sformatf("R4 last flag byte %0d", o), out_last, (o == 13));
      if (o != 0) check("R2 R8 in_ready low while draining", in_ready, 0);
      if (junk) in_data = 8'($urandom);
      @(negedge clk);
      out_ready = 1'b0;
    end
    in_valid = 1'b0;
    check("R4 ready again after last", in_ready, 1);
    check("R4 no valid after last", out_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 in_ready after reset", in_ready, 1);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 out_last after reset", out_last, 0);

    run_block(56'h0, 1'b0, 1'b0, 1'b0, "all-zero");
    run_block({56{1'b1}}, 1'b0, 1'b0, 1'b0, "all-ones");
    run_block(56'h0, 1'b0, 1'b0, 1'b0, "zero after ones");
    for (int b = 0; b < 56; b++)
      run_block(56'h1 << b, 1'b0, 1'b0, 1'b0, $sformatf("single bit %0d", b));
    for (int r = 0; r < 40; r++)
      run_block({$urandom, 24'($urandom)}, r[0], r[1], r[2],
                $sformatf("R9 random %0d", r));
    // output stall held across several cycles
    begin
      logic [111:0] e2;
      logic [55:0]  blk2;
      blk2 = 56'h00_1B_3C_80_83_B1_12;
      e2 = ref_enc(blk2);
      for (int i = 0; i < 7; i++) begin
        in_valid = 1'b1; in_data = blk2[8*i +: 8];
        @(negedge clk);
      end
      in_valid = 1'b0;
      out_ready = 1'b0;
      repeat (4) @(negedge clk);
      check("R5 data held under stall", out_data, e2[7:0]);
      check("R5 valid held under stall", out_valid, 1);
      for (int o = 0; o < 14; o++) begin
        out_ready = 1'b1;
        check($sformatf("R7 stalled block byte %0d", o), out_data, e2[8*o +: 8]);
        @(negedge clk);
      end
      out_ready = 1'b0;
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule